// File: doc/BRIEF.md
# AC-Bias Polarity and Output-Enable Generator

This block drives the single AC-bias pin of a flat-panel controller. In passive mode the pin is a slow polarity signal. A reloadable down-counter counts line-clock pulses, and each time the count runs out the pin inverts, so the panel can reverse the polarity of its drive and avoid a standing DC offset. The programmed interval is the wanted number of line clocks minus one.

In active mode the same pin becomes a data-valid strobe. It follows the pixel-data-active flag, and the programmed interval has no effect. While the controller is disabled the pin is low. Every entry into passive running, whether from enable or from active mode, starts from a fresh load of the interval with the polarity low.

Top module: `acbias_gen`

## Requirements
- R1: While `en` is low, `ac_out` is low in both modes, whatever the other inputs are.
- R2: On the first cycle of passive running (`en` high and `active_mode` low after being disabled), the counter loads `interval` and the polarity is set low. A `line_pulse` in that load cycle is not counted.
- R3: In passive running, `ac_out` inverts after every `interval`+1 counted line pulses. The output changes in the cycle after the pulse that expires the count. An `interval` of 0 inverts the output on every pulse, and 255 inverts it every 256 pulses.
- R4: The counter and the polarity change only in cycles where `line_pulse` is high. Cycles without a pulse leave `ac_out` unchanged.
- R5: A change of `interval` during a count takes effect at the next reload. The count already in progress finishes with the old value.
- R6: In active mode with `en` high, `ac_out` equals `pix_valid` in the same cycle, and `interval` and `line_pulse` have no effect on it.
- R7: A switch from active to passive mode restarts the count as in R2, with the polarity low and a fresh load of `interval`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Controller enable |
| active_mode | input | 1 | 1 = active (strobe) mode, 0 = passive (polarity) mode |
| interval | input | CW | Line clocks between transitions, minus one |
| line_pulse | input | 1 | One-cycle line-clock pulse, synchronous to clk |
| pix_valid | input | 1 | Pixel data is on the data pins |
| ac_out | output | 1 | AC-bias pin |

## Verification
A wrong count or a missed reload shows as a transition of `ac_out` one or more line pulses early or late. The bench sweeps intervals from 0 to 20, plus 100 and 255, and checks the pin after every pulse, so any such error is reported at the first pulse where the pin differs. A polarity left over from an earlier run appears as a high pin straight after enable or after a mode switch, which is checked in the next cycle. Leakage of the count into active mode shows as the pin departing from `pix_valid`, which is checked in every active cycle.

// File: rtl/acbias_gen.sv
module acbias_gen #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          active_mode,
  input  logic [CW-1:0] interval,
  input  logic          line_pulse,
  input  logic          pix_valid,
  output logic          ac_out
);

  logic [CW-1:0] cnt;
  logic          pol;
  logic          run_q;

  wire passive_on = en & ~active_mode;
  wire load       = passive_on & ~run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pol   <= 1'b0;
      run_q <= 1'b0;
    end else begin
      run_q <= passive_on;
      if (!passive_on) begin
        pol <= 1'b0;
      end else if (load) begin
        cnt <= interval;
        pol <= 1'b0;
      end else if (line_pulse) begin
        if (cnt == '0) begin
          cnt <= interval;
          pol <= ~pol;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign ac_out = en & (active_mode ? pix_valid : pol);

  // R2 / R7: fresh load with polarity low on entry to passive running
  a_r2_fresh_load: assert property (@(posedge clk) disable iff (!rst_n)
    (passive_on && !run_q) |=> (!pol && cnt == $past(interval)));

  // R3: expiry inverts polarity and reloads
  a_r3_toggle_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (passive_on && run_q && line_pulse && cnt == '0) |=>
      (pol != $past(pol) && cnt == $past(interval)));

  // R3: non-zero count steps down by one and keeps polarity
  a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (passive_on && run_q && line_pulse && cnt != '0) |=>
      (cnt == $past(cnt) - 1'b1 && $stable(pol)));

  // R4: no pulse, no change
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (passive_on && run_q && !line_pulse) |=> ($stable(cnt) && $stable(pol)));

  // R1: pin low while disabled
  a_r1_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !ac_out);

endmodule

// File: tb/acbias_gen_tb.sv
module acbias_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, active_mode = 1'b0;
  logic [7:0] interval = 8'd0;
  logic line_pulse = 1'b0, pix_valid = 1'b0;
  logic ac_out;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acbias_gen #(.CW(8)) dut_i (.*);

  task automatic check(input logic exp, input string req);
    n_chk++;
    if (ac_out !== exp) begin
      n_bad++;
      $display("FAIL %s: ac_out=%b expected=%b at %0t", req, ac_out, exp, $time);
    end
  endtask

  task automatic tick(input logic p);
    line_pulse = p;
    @(negedge clk);
    line_pulse = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_bad++;
    $display("FAIL watchdog: ac_out=%b expected=done", ac_out);
    summary();
    $finish;
  end

  initial begin
    logic expv;
    int ivs[$];
    repeat (3) @(negedge clk);
    check(1'b0, "R1 reset");
    rst_n = 1'b1;
    tick(1'b1);
    check(1'b0, "R1 disabled");

    for (int i = 0; i <= 20; i++) ivs.push_back(i);
    ivs.push_back(100);
    ivs.push_back(255);
    foreach (ivs[k]) begin
      interval = ivs[k][7:0];
      en = 1'b0; active_mode = 1'b0;
      tick(1'b0);
      check(1'b0, "R1 off");
      en = 1'b1;
      tick(1'b1);
      check(1'b0, "R2 load cycle");
      expv = 1'b0;
      for (int t = 0; t < 3; t++) begin
        for (int p = 0; p <= ivs[k]; p++) begin
          tick(1'b1);
          if (p == ivs[k]) expv = ~expv;
          check(expv, "R3 interval sweep");
          tick(1'b0);
          check(expv, "R4 idle hold");
        end
      end
    end

    // R1: disable while high
    interval = 8'd0; en = 1'b0; tick(1'b0);
    en = 1'b1; tick(1'b0); tick(1'b1);
    check(1'b1, "R3 high before disable");
    en = 1'b0; #1;
    check(1'b0, "R1 disable drops pin");
    tick(1'b1);
    check(1'b0, "R1 disabled pulse");

    // R5: mid-count change
    interval = 8'd3; en = 1'b1; tick(1'b0);
    tick(1'b1); tick(1'b1);
    interval = 8'd1;
    tick(1'b1);
    check(1'b0, "R5 old count still running");
    tick(1'b1);
    check(1'b1, "R5 old count expiry");
    tick(1'b1);
    check(1'b1, "R5 new value first pulse");
    tick(1'b1);
    check(1'b0, "R5 new value expiry");

    // R6: active mode follows pix_valid
    active_mode = 1'b1;
    for (int v = 0; v < 32; v++) begin
      pix_valid = v[0]; interval = v[7:0] * 8'd7;
      #1;
      check(v[0], "R6 strobe follows");
      tick(v[1]);
      check(v[0], "R6 after pulse");
    end
    en = 1'b0; pix_valid = 1'b1; #1;
    check(1'b0, "R1 active disabled");
    en = 1'b1; #1;
    check(1'b1, "R6 active enabled");

    // R7: active to passive restarts
    active_mode = 1'b0; interval = 8'd0; pix_valid = 1'b0;
    tick(1'b1);
    check(1'b0, "R2 passive load");
    tick(1'b1);
    check(1'b1, "R7 pre-switch high");
    active_mode = 1'b1; tick(1'b1);
    check(1'b0, "R6 pix low");
    active_mode = 1'b0; interval = 8'd2;
    tick(1'b1);
    check(1'b0, "R7 fresh load low");
    tick(1'b1); tick(1'b1);
    check(1'b0, "R7 two pulses");
    tick(1'b1);
    check(1'b1, "R7 expiry");

    summary();
    $finish;
  end
endmodule